// File: doc/BRIEF.md
# Two-wire register-access slave

This block connects an external two-wire bus master to a bank of 16-bit registers. The master can read and write these registers. The block samples the serial clock and data lines on the system clock and recognises start and stop conditions. It responds to a 7-bit device address: a fixed five-bit prefix followed by two bits taken from strap inputs, so four copies can share one bus. It acknowledges each byte it accepts and drives the data line only by pulling it low.

A write transaction begins by loading a 16-bit register pointer from two bytes, high byte first. Each following pair of bytes is stored to the register the pointer selects, and the pointer then advances. A read returns each register as two bytes, high byte first, and moves the pointer on after each register until the master declines a byte. A stop condition always clears the pointer to zero. A repeated start keeps the pointer, so a master can set an address with a write and then read from it. The register bank is outside this block and is reached through an address, write-data and write-strobe port, with combinational read data coming back.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The block answers only to the 7-bit address formed by binary 01011 followed by `strap_a1` and then `strap_a0`, sent MSB first and followed by a direction bit (0 = master writes, 1 = master reads). On a match it pulls SDA low for the ninth clock pulse.
- R2: A falling SDA while SCL is high is a start and begins a new address byte. A rising SDA while SCL is high is a stop and returns the block to idle.
- R3: The block changes its SDA drive only while SCL is low, and it drives SDA only low (open drain).
- R4: After an address that does not match, the block leaves SDA released and writes nothing until the next start.
- R5: In a write, every data byte is acknowledged. The first two data bytes load the register pointer, high byte first, and the pointer is visible on `reg_addr`.
- R6: In a write, each later pair of bytes (high byte first) raises `reg_we` for exactly one system clock, with `reg_addr` equal to the pointer and `reg_wdata` equal to the pair. The pointer then increases by one.
- R7: A stop condition clears the register pointer to 0.
- R8: In a read, each register is sent as its high byte and then its low byte, MSB first. The pointer increases by one after each low byte, so consecutive registers follow one another.
- R9: A repeated start keeps the pointer value, so a read that follows a pointer-loading write starts at that pointer.
- R10: When the master does not acknowledge a read byte, the block releases SDA until the next start or stop, and further clock pulses read as all ones.
- R11: While reset is held and right after it, SDA is released, `reg_we` is low and `reg_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_a1 | input | 1 | Higher strap bit of the device address |
| strap_a0 | input | 1 | Lower strap bit of the device address |
| reg_addr | output | 16 | Register pointer, used for both reads and writes |
| reg_wdata | output | 16 | Data for a register write |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 16 | Register contents at `reg_addr` |

## Verification
Some properties are checked on every cycle:
- The SDA drive never changes while the synchronised SCL is high.
- The drive stays released whenever the block is idle.
- Every write strobe is a single cycle that falls inside a write acknowledge.
- The pointer reads zero after a stop.

Other behaviours appear only in the bench's bus scenarios:
- The address match against each strap setting, including the rejected ones.
- The pointer loading order.
- The byte order of reads and writes.
- The pointer carried across a repeated start.
- The all-ones bus after a master's NACK.

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter logic [4:0] DEV_PREFIX = 5'b01011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        strap_a1,
  input  logic        strap_a0,
  output logic [15:0] reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  input  logic [15:0] reg_rdata
);
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK} st_t;

  st_t st;
  logic [1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic [BYTE_W-1:0] sr, tx, hold;
  logic [3:0] cnt;
  logic [1:0] wph;
  logic [DATA_W-1:0] ptr;
  logic rw, lo_next, mack;

  wire scl_s = scl_sync[1];
  wire sda_s = sda_sync[1];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det = scl_s & scl_q & ~sda_q & sda_s;
  wire [6:0] dev_addr = {DEV_PREFIX, strap_a1, strap_a0};
  wire [BYTE_W-1:0] next_byte = lo_next ? reg_rdata[BYTE_W-1:0] : reg_rdata[DATA_W-1:BYTE_W];

  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sr <= '0;
      tx <= '0;
      hold <= '0;
      cnt <= '0;
      wph <= '0;
      ptr <= '0;
      rw <= 1'b0;
      lo_next <= 1'b0;
      mack <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
      reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 1'b1;
      if (start_det) begin
        st <= S_ADDR;
        cnt <= '0;
        wph <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE;
        wph <= '0;
        ptr <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WBYTE: begin
            if (scl_rise) begin
              sr <= {sr[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == LAST_BIT) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sr[BYTE_W-1:1] == dev_addr) begin
                  st <= S_AACK;
                  sda_oe <= 1'b1;
                  rw <= sr[0];
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                st <= S_WACK;
                sda_oe <= 1'b1;
                case (wph)
                  2'd0: ptr[DATA_W-1:BYTE_W] <= sr;
                  2'd1: ptr[BYTE_W-1:0] <= sr;
                  2'd2: hold <= sr;
                  default: begin
                    reg_we <= 1'b1;
                    reg_wdata <= {hold, sr};
                  end
                endcase
                wph <= (wph == 2'd3) ? 2'd2 : wph + 1'b1;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                st <= S_RBYTE;
                tx <= reg_rdata[DATA_W-1:BYTE_W];
                sda_oe <= ~reg_rdata[DATA_W-1];
                lo_next <= 1'b1;
              end else begin
                st <= S_WBYTE;
                sda_oe <= 1'b0;
              end
            end
          end
          S_WACK: begin
            if (scl_fall) begin
              st <= S_WBYTE;
              sda_oe <= 1'b0;
            end
          end
          S_RBYTE: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT - 1'b1) begin
                st <= S_RACK;
                sda_oe <= 1'b0;
                if (!lo_next) ptr <= ptr + 1'b1;
              end else begin
                tx <= {tx[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx[BYTE_W-2];
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (mack) begin
                st <= S_RBYTE;
                tx <= next_byte;
                sda_oe <= ~next_byte[BYTE_W-1];
                lo_next <= ~lo_next;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R4
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R6
  AST_WE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (st == S_WACK)); // R6
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (reg_addr == '0)); // R7
endmodule

// File: tb/i2c_regbank_slave_tb_top.sv
module i2c_regbank_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic a1 = 1'b1;
  logic a0 = 1'b0;
  logic sda_oe, reg_we;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  logic [15:0] mem [16];
  logic [31:0] exp_wr [$];
  int n_cmp = 0;
  int n_bad = 0;
  int oe_hi_changes = 0;
  logic oe_prev = 1'b0;
  logic done = 1'b0;

  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_regbank_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a1(a1), .strap_a0(a0), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr[3:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 16'hA500 + 16'(i);
    end else if (reg_we) begin
      mem[reg_addr[3:0]] <= reg_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops an expected write for every strobe
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe !== oe_prev && scl_m) oe_hi_changes++;
      oe_prev = sda_oe;
      if (reg_we) begin
        if (exp_wr.size() == 0) check("R6 unexpected write", {reg_addr, reg_wdata}, 32'hxxxxxxxx);
        else check("R6 write addr/data", {reg_addr, reg_wdata}, exp_wr.pop_front());
      end
    end
  end

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    scl_m = 1'b0; qwait; sda_m = 1'b1; qwait;
    scl_m = 1'b1; qwait; sda_m = 1'b0; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    scl_m = 1'b0; sda_m = 1'b0; qwait;
    scl_m = 1'b1; qwait; sda_m = 1'b1; qwait;
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; qwait;
    scl_m = 1'b1; qwait;
    s = sda_line; qwait;
    scl_m = 1'b0; qwait;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic wr_ok(input logic [7:0] b, input string req);
    logic ack;
    put_byte(b, ack);
    check(req, {31'd0, ack}, 32'd1);
  endtask

  task automatic rd_exp(input logic give_ack, input logic [7:0] e, input string req);
    logic [7:0] b;
    get_byte(give_ack, b);
    check(req, {24'd0, b}, {24'd0, e});
  endtask

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    check("R11 sda released in reset", {31'd0, sda_oe}, 32'd0);
    check("R11 we low in reset", {31'd0, reg_we}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 pointer zero", {16'd0, reg_addr}, 32'd0);

    // R4: wrong address 0x2C
    bus_start;
    put_byte(8'h58, ack);
    check("R4 no ack on mismatch", {31'd0, ack}, 32'd0);
    put_byte(8'h00, ack);
    check("R4 stays idle", {31'd0, ack}, 32'd0);
    bus_stop;

    // R1/R5: pointer load, then R7 stop clears it
    bus_start;
    wr_ok(8'h5C, "R1 address ack");
    wr_ok(8'h01, "R5 pointer hi ack");
    wr_ok(8'h02, "R5 pointer lo ack");
    check("R5 pointer value", {16'd0, reg_addr}, 32'h0102);
    bus_stop;
    repeat (4) @(negedge clk);
    check("R7 pointer cleared on stop", {16'd0, reg_addr}, 32'd0);

    // R6: two register writes
    exp_wr.push_back({16'd3, 16'h1234});
    exp_wr.push_back({16'd4, 16'hABCD});
    bus_start;
    wr_ok(8'h5C, "R1 address ack");
    wr_ok(8'h00, "R5 ack");
    wr_ok(8'h03, "R5 ack");
    wr_ok(8'h12, "R5 data ack");
    wr_ok(8'h34, "R5 data ack");
    wr_ok(8'hAB, "R5 data ack");
    wr_ok(8'hCD, "R5 data ack");
    check("R6 pointer advanced", {16'd0, reg_addr}, 32'd5);
    bus_stop;

    // R7/R8/R10: read from 0 after stop, NACK last byte
    bus_start;
    wr_ok(8'h5D, "R1 read address ack");
    rd_exp(1'b1, 8'hA5, "R8 reg0 hi");
    rd_exp(1'b1, 8'h00, "R8 reg0 lo");
    rd_exp(1'b1, 8'hA5, "R8 reg1 hi");
    rd_exp(1'b1, 8'h01, "R8 reg1 lo");
    rd_exp(1'b1, 8'hA5, "R8 reg2 hi");
    rd_exp(1'b0, 8'h02, "R8 reg2 lo");
    rd_exp(1'b0, 8'hFF, "R10 released after nack");
    bus_stop;

    // R9: repeated start keeps pointer
    bus_start;
    wr_ok(8'h5C, "R1 address ack");
    wr_ok(8'h00, "R5 ack");
    wr_ok(8'h03, "R5 ack");
    bus_start;
    wr_ok(8'h5D, "R2 repeated start address ack");
    rd_exp(1'b1, 8'h12, "R9 reg3 hi");
    rd_exp(1'b1, 8'h34, "R9 reg3 lo");
    rd_exp(1'b1, 8'hAB, "R9 reg4 hi");
    rd_exp(1'b0, 8'hCD, "R9 reg4 lo");
    bus_stop;

    // R1: other strap setting
    a1 = 1'b0; a0 = 1'b1;
    repeat (4) @(negedge clk);
    bus_start;
    put_byte(8'h5C, ack);
    check("R1 old address rejected", {31'd0, ack}, 32'd0);
    bus_stop;
    bus_start;
    wr_ok(8'h5A, "R1 strap address ack");
    bus_stop;

    check("R3 drive changed with SCL high", oe_hi_changes, 32'd0);
    check("R6 all expected writes seen", exp_wr.size(), 32'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule